// File: doc/BRIEF.md
# Gigabit Ethernet PCS Transmit Framer

This block converts a byte-wide transmit stream (enable, error flag, eight data bits, one byte per clock) into the 1000BASE-X code-group sequence that feeds an 8b/10b encoder. It emits one 8-bit symbol per clock with a control/data flag. Between frames it sends two-symbol idle ordered sets. Each frame is wrapped in a start delimiter and an end delimiter, and the end delimiter is followed by one or two carrier-extend symbols.

The framer keeps a one-bit code-group position that alternates every clock. The position decides three things: where a frame may start, how many carrier-extend symbols close it, and where each idle begins. The encoder reports its running disparity on an input. The framer uses that value to choose the idle variant, so that after any disturbance the idle commas return to negative disparity.

A start delimiter is an extra code group in front of the data. The incoming bytes therefore pass through a short hold line, and each frame is read from it one or two cycles late. The delay depends on the position at which the frame arrived. The sender must leave at least 12 idle clocks between frames.

Top module: `pcs_tx_framer`

## Requirements
- R1: While reset is asserted, the outputs hold `cg_sym`=0x50, `cg_ctl`=0 and `cg_odd`=1.
- R2: `cg_odd` alternates on every clock after reset. The first code group after reset is even (`cg_odd`=0).
- R3: An idle ordered set is the comma 0xBC with `cg_ctl`=1 on an even position, followed by 0x50 or 0xC5 with `cg_ctl`=0 on the next, odd position.
- R4: The second idle symbol is 0xC5 (disparity flipping) if `enc_rd_pos` was 1 on the clock edge that registered the comma. Otherwise it is 0x50 (disparity keeping).
- R5: The start delimiter 0xFB with `cg_ctl`=1 appears only on an even position. If `tx_valid` rises when the next slot is odd, the framer first completes the idle with its second symbol, then sends the start delimiter.
- R6: After the start delimiter, the frame bytes follow in order, one per clock, with `cg_ctl`=0.
- R7: A byte that was presented with `tx_fault`=1 while `tx_valid`=1 is replaced by 0xFE with `cg_ctl`=1.
- R8: The end delimiter 0xFD with `cg_ctl`=1 directly follows the last frame byte.
- R9: One carrier-extend symbol 0xF7 with `cg_ctl`=1 follows the end delimiter. A second 0xF7 is added when the first falls on an even position. The next code group is an idle comma on an even position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Frame byte present |
| tx_fault | input | 1 | Current byte must be sent as an error symbol |
| tx_data | input | 8 | Frame byte |
| enc_rd_pos | input | 1 | Encoder running disparity is positive for the next code group |
| cg_sym | output | 8 | Code-group value to encode |
| cg_ctl | output | 1 | 1 = control code group, 0 = data code group |
| cg_odd | output | 1 | Position of the current code group (1 = odd) |

## Verification
The bench builds the framer with its default two-stage hold line. This is the only depth at which a held start can still be served without losing bytes. That small setting allows a full sweep of the following:
- frame lengths from one to six bytes;
- both arrival positions, which select the one-cycle and two-cycle read-out;
- both disparity values;
- an error byte at the first position, at the last position, or absent.

Together these reach every end-sequence length and every idle variant. Each output symbol is predicted from edge counts alone.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
  localparam logic [7:0] CG_COMMA     = 8'hBC;
  localparam logic [7:0] CG_SOP       = 8'hFB;
  localparam logic [7:0] CG_EOP       = 8'hFD;
  localparam logic [7:0] CG_EXT       = 8'hF7;
  localparam logic [7:0] CG_ERR       = 8'hFE;
  localparam logic [7:0] CG_IDLE_FLIP = 8'hC5;
  localparam logic [7:0] CG_IDLE_KEEP = 8'h50;

  typedef enum logic [1:0] {FR_IDLE, FR_DATA, FR_EXT1, FR_EXT2} fr_state_e;

  typedef struct packed {
    logic       en;
    logic       er;
    logic [7:0] d;
  } tx_beat_t;

  // second symbol of an idle ordered set
  function automatic logic [7:0] idle_tail(input logic flip);
    return flip ? CG_IDLE_FLIP : CG_IDLE_KEEP;
  endfunction

  // an extend symbol on an even slot needs a partner so the idle lands even
  function automatic logic ext_needs_second(input logic ext_on_even);
    return ext_on_even;
  endfunction

  // symbol and flag for a frame byte
  function automatic logic [8:0] frame_symbol(input tx_beat_t b);
    return b.er ? {1'b1, CG_ERR} : {1'b0, b.d};
  endfunction
endpackage

// File: rtl/pcs_tx_delay.sv
module pcs_tx_delay
  import pcs_tx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tx_beat_t din,
  output tx_beat_t tap [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    tx_beat_t q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= din;
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= g_st[i-1].q;
    end
    assign tap[i] = q;
  end
endmodule

// File: rtl/pcs_tx_phase.sv
module pcs_tx_phase (
  input  logic clk,
  input  logic rst_n,
  output logic cg_odd,
  output logic next_even
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cg_odd <= 1'b1;
    else        cg_odd <= ~cg_odd;

  assign next_even = cg_odd;
endmodule

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
  import pcs_tx_pkg::*;
#(
  parameter int HOLD_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic       tx_fault,
  input  logic [7:0] tx_data,
  input  logic       enc_rd_pos,
  output logic [7:0] cg_sym,
  output logic       cg_ctl,
  output logic       cg_odd
);
  localparam int LATE_TAP = HOLD_DEPTH - 1;

  tx_beat_t  beat_in, beat_sel;
  tx_beat_t  taps [HOLD_DEPTH];
  fr_state_e state_q, state_d;
  logic      late_q, late_d;
  logic      flip_q, flip_d;
  logic [7:0] sym_d;
  logic       ctl_d;
  logic       next_even;

  // named events for the checker
  logic start_req, sof_fire, eof_fire, emit_comma;

  assign beat_in = '{en: tx_valid, er: tx_fault & tx_valid, d: tx_data};

  pcs_tx_delay #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .din(beat_in), .tap(taps)
  );

  pcs_tx_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cg_odd(cg_odd), .next_even(next_even)
  );

  assign beat_sel   = late_q ? taps[LATE_TAP] : taps[0];
  assign start_req  = tx_valid | taps[0].en;
  assign sof_fire   = (state_q == FR_IDLE) && next_even && start_req;
  assign emit_comma = (state_q == FR_IDLE) && next_even && !start_req;
  assign eof_fire   = (state_q == FR_DATA) && !beat_sel.en;

  always_comb begin
    state_d = state_q;
    late_d  = late_q;
    flip_d  = flip_q;
    sym_d   = CG_COMMA;
    ctl_d   = 1'b1;
    unique case (state_q)
      FR_IDLE: begin
        if (sof_fire) begin
          sym_d   = CG_SOP;
          late_d  = taps[0].en;
          state_d = FR_DATA;
        end else if (emit_comma) begin
          flip_d = enc_rd_pos;
        end else begin
          sym_d = idle_tail(flip_q);
          ctl_d = 1'b0;
        end
      end
      FR_DATA: begin
        if (eof_fire) begin
          sym_d   = CG_EOP;
          state_d = FR_EXT1;
        end else begin
          {ctl_d, sym_d} = frame_symbol(beat_sel);
        end
      end
      FR_EXT1: begin
        sym_d   = CG_EXT;
        state_d = ext_needs_second(next_even) ? FR_EXT2 : FR_IDLE;
      end
      FR_EXT2: begin
        sym_d   = CG_EXT;
        state_d = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= FR_IDLE;
      late_q  <= 1'b0;
      flip_q  <= 1'b0;
      cg_sym  <= CG_IDLE_KEEP;
      cg_ctl  <= 1'b0;
    end else begin
      state_q <= state_d;
      late_q  <= late_d;
      flip_q  <= flip_d;
      cg_sym  <= sym_d;
      cg_ctl  <= ctl_d;
    end
endmodule

// File: rtl/pcs_tx_framer_chk.sv
module pcs_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cg_sym,
  input logic       cg_ctl,
  input logic       cg_odd,
  input logic       enc_rd_pos,
  input logic       emit_comma,
  input logic       sof_fire
);
  logic is_comma, is_sop, is_eop, is_ext;
  assign is_comma = cg_ctl && cg_sym == 8'hBC;
  assign is_sop   = cg_ctl && cg_sym == 8'hFB;
  assign is_eop   = cg_ctl && cg_sym == 8'hFD;
  assign is_ext   = cg_ctl && cg_sym == 8'hF7;

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cg_odd != $past(cg_odd)); // R2
  AST_COMMA_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_comma |-> !cg_odd); // R3
  AST_COMMA_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    is_comma |=> !cg_ctl && (cg_sym == 8'hC5 || cg_sym == 8'h50)); // R3
  AST_TAIL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    emit_comma && enc_rd_pos |=> ##1 cg_sym == 8'hC5); // R4
  AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    emit_comma && !enc_rd_pos |=> ##1 cg_sym == 8'h50); // R4
  AST_SOP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_sop |-> !cg_odd); // R5
  AST_SOF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sof_fire |=> is_sop); // R5
  AST_EOP_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    is_eop |=> is_ext); // R9
  AST_EXT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_ext && cg_odd |=> is_comma); // R9
  AST_EXT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    is_ext && !cg_odd |=> is_ext); // R9
endmodule

bind pcs_tx_framer pcs_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cg_sym(cg_sym), .cg_ctl(cg_ctl), .cg_odd(cg_odd),
  .enc_rd_pos(enc_rd_pos), .emit_comma(emit_comma), .sof_fire(sof_fire)
);

// File: tb/sim_pcs_tx_framer.sv
`timescale 1ns/1ps
module sim_pcs_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, tx_fault = 1'b0, enc_rd_pos = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] cg_sym;
  logic       cg_ctl, cg_odd;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int ecount = 0;
  logic [7:0] cap_sym [0:4095];
  logic       cap_ctl [0:4095];
  logic       cap_odd [0:4095];

  always #2.5 clk = ~clk;

  pcs_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_fault(tx_fault),
    .tx_data(tx_data), .enc_rd_pos(enc_rd_pos),
    .cg_sym(cg_sym), .cg_ctl(cg_ctl), .cg_odd(cg_odd)
  );

  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;
  always @(negedge clk) begin
    cap_sym[ecount % 4096] <= cg_sym;
    cap_ctl[ecount % 4096] <= cg_ctl;
    cap_odd[ecount % 4096] <= cg_odd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cg(input int e, input logic [7:0] s, input logic c,
                        input string req);
    int i = e % 4096;
    chk(cap_sym[i] == s && cap_ctl[i] == c, req, $sformatf("edge %0d", e),
        {cap_ctl[i], cap_sym[i]}, {c, s});
  endtask

  function automatic logic [7:0] byte_of(input int len, input int j);
    return 8'((j * 37 + len * 5 + 3) & 8'hFF);
  endfunction

  // late = 1: tx_valid seen on an edge whose output would be odd
  task automatic run_frame(input int len, input bit late, input bit rdv,
                           input int err_at);
    int k0, sop, t, r1, nx;
    enc_rd_pos = rdv;
    @(negedge clk); @(negedge clk);
    while ((((ecount + 1) % 2) == 0) != late) @(negedge clk);
    k0 = ecount + 1;
    for (int j = 0; j < len; j++) begin
      tx_valid = 1'b1;
      tx_fault = (j == err_at);
      tx_data  = byte_of(len, j);
      @(negedge clk);
    end
    tx_valid = 1'b0; tx_fault = 1'b0;
    for (int w = 0; w < len + 14; w++) @(negedge clk);

    sop = late ? k0 + 1 : k0;
    if (late) chk_cg(k0, rdv ? 8'hC5 : 8'h50, 1'b0, "R5 held start");
    chk_cg(sop, 8'hFB, 1'b1, "R5 start");
    chk(cap_odd[sop % 4096] == 1'b0, "R5", "start position", cap_odd[sop % 4096], 0);
    for (int j = 0; j < len; j++) begin
      if (j == err_at) chk_cg(sop + 1 + j, 8'hFE, 1'b1, "R7 error byte");
      else             chk_cg(sop + 1 + j, byte_of(len, j), 1'b0, "R6 data");
    end
    t  = sop + len + 1;
    chk_cg(t, 8'hFD, 1'b1, "R8 end");
    r1 = t + 1;
    chk_cg(r1, 8'hF7, 1'b1, "R9 extend");
    if (r1 % 2 == 1) begin
      chk_cg(r1 + 1, 8'hF7, 1'b1, "R9 second extend");
      nx = r1 + 2;
    end else nx = r1 + 1;
    chk_cg(nx, 8'hBC, 1'b1, "R9 idle after end");
    chk(cap_odd[nx % 4096] == 1'b0, "R9", "idle position", cap_odd[nx % 4096], 0);
    chk_cg(nx + 1, rdv ? 8'hC5 : 8'h50, 1'b0, "R4 idle variant");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cg_sym == 8'h50 && cg_ctl == 1'b0 && cg_odd == 1'b1, "R1", "reset outputs",
        {cg_odd, cg_ctl, cg_sym}, {1'b1, 1'b0, 8'h50});
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    for (int e = 1; e <= 8; e++) begin
      if (e % 2 == 1) chk_cg(e, 8'hBC, 1'b1, "R3 comma");
      else            chk_cg(e, 8'h50, 1'b0, "R3 R4 keep tail");
    end
    for (int len = 1; len <= 6; len++)
      for (int lt = 0; lt < 2; lt++)
        for (int rd = 0; rd < 2; rd++)
          for (int ek = 0; ek < 3; ek++)
            run_frame(len, lt[0], rd[0], ek == 0 ? -1 : (ek == 1 ? 0 : len - 1));
    begin
      int bad = 0;
      for (int e = 1; e < ecount && e < 4096; e++)
        if (cap_odd[e] != ((e % 2) == 0)) bad++;
      chk(bad == 0, "R2", "position sweep mismatches", bad, 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule